// File: doc/BRIEF.md
# Video Clock Divider with Half-Step Pre-Divide

This block derives a slow clock-enable stream for a video pixel path from one of three candidate sources: a crystal oscillator and two PLL outputs. Each source is presented to the block as a single-cycle strobe that fires once per half period of that source. This gives a reference at twice the source rate, so a pre-divide ratio of 2.5 can be built from whole counts and is exact.

Software programs a single 16-bit configuration register. The register selects the source, picks a pre-divide ratio of 2, 2.5 or 3, sets an integer post-divide value and turns the output on or off. The output is a one-cycle pulse, `clk_en_o`, in the block's own clock domain. Its average rate is the source rate divided by the product of the pre-divide ratio and the post-divide value. Any illegal setting holds the output idle. Every write to the register restarts both counters, so a period from an old setting never reaches the output.

Top module: `vclk_gen`

## Requirements
- R1: After reset `clk_en_o` is 0 and `cfg_rdata` reads 0x0000.
- R2: A write (`cfg_we` high at a clock edge) stores all 16 bits of `cfg_wdata`, and `cfg_rdata` shows them from the following cycle.
- R3: Source select uses bit 13 (use-PLL) and bit 14 (PLL pick). With bit 13 clear the oscillator strobe `src_half_tick[0]` is used and bit 14 is ignored. With bit 13 set, bit 14 clear selects PLL1 (`src_half_tick[1]`) and bit 14 set selects PLL2 (`src_half_tick[2]`).
- R4: The pre-divide code in bits [8:7] sets the pre-divide length: code 1 gives 4 half periods (ratio 2), code 2 gives 5 (ratio 2.5) and code 3 gives 6 (ratio 3).
- R5: The post-divide value in bits [6:0] multiplies the pre-divide length. With legal settings, consecutive one-cycle output pulses are exactly (pre-divide half periods × post-divide value) selected half-period strobes apart.
- R6: A post-divide value of 0 or 1 is illegal and holds `clk_en_o` at 0; the legal range is 2 to 127.
- R7: A pre-divide code of 0 is illegal and holds `clk_en_o` at 0.
- R8: Bit 15 is the output enable. While it is clear, `clk_en_o` stays 0.
- R9: A write clears both divide counters. `clk_en_o` is 0 in the cycle after the write. The first pulse needs a full count of strobes that arrive after the write.
- R10: The output rate never exceeds one quarter of the selected source. Pulses are at least 8 half periods apart, and `clk_en_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration register contents |
| src_half_tick | input | 3 | Half-period strobes: [0] oscillator, [1] PLL1, [2] PLL2 |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
The assertions check on every cycle the properties that hold at each clock edge. The write path stores the value. Output pulses never occur back to back. The output is quiet right after a write and while the setting is disabled or illegal. Both divide counters stay below their terminal values. The scenarios are the only way to show that the pulse spacing is the product of the right pre-divide length and post-divide value for the selected source. They also show that the unused select bit is ignored and that the first pulse after a write takes a full count. To do this the bench measures the cycles between pulses under sources of different strobe rates.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
    localparam int CFG_W    = 16;
    localparam int DIV_W    = 7;
    localparam int PRE_W    = 2;
    localparam int NUM_SRC  = 3;
    localparam int HALF_W   = 3;
    localparam int DIV_LSB  = 0;
    localparam int PRE_LSB  = 7;
    localparam int ESEL_BIT = 13;
    localparam int PSEL_BIT = 14;
    localparam int EN_BIT   = 15;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_PLL1 = 2'd1,
        SRC_PLL2 = 2'd2
    } src_sel_e;

    typedef struct packed {
        logic             en;
        logic             use_pll;
        logic             pll_pick;
        logic [PRE_W-1:0] pre_code;
        logic [DIV_W-1:0] post_div;
    } cfg_fields_t;

    function automatic cfg_fields_t unpack_cfg(input logic [CFG_W-1:0] r);
        cfg_fields_t f;
        f.en       = r[EN_BIT];
        f.use_pll  = r[ESEL_BIT];
        f.pll_pick = r[PSEL_BIT];
        f.pre_code = r[PRE_LSB +: PRE_W];
        f.post_div = r[DIV_LSB +: DIV_W];
        return f;
    endfunction
endpackage

// File: rtl/vclk_cfg_reg.sv
module vclk_cfg_reg #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/vclk_src_mux.sv
module vclk_src_mux #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               use_pll,
    input  logic               pll_pick,
    output logic               half_tick
);
    import vclk_pkg::*;

    src_sel_e           sel;
    logic [NUM_SRC-1:0] pick;
    logic [NUM_SRC-1:0] gated;

    always_comb begin
        if (!use_pll) begin
            sel = SRC_OSC;
        end else if (!pll_pick) begin
            sel = SRC_PLL1;
        end else begin
            sel = SRC_PLL2;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
        assign pick[g]  = (int'(sel) == g);
        assign gated[g] = pick[g] & src_tick[g];
    end

    assign half_tick = |gated;
endmodule

// File: rtl/vclk_prediv.sv
module vclk_prediv #(
    parameter int HALF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              half_tick,
    input  logic [HALF_W-1:0] half_units,
    output logic              pre_tick
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   at_end;

    assign at_end = (st_q.cnt == half_units - HALF_W'(1));

    always_comb begin
        st_d     = st_q;
        pre_tick = 1'b0;
        if (clr || !run) begin
            st_d.cnt = '0;
        end else if (half_tick) begin
            if (at_end) begin
                st_d.cnt = '0;
                pre_tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (st_q.cnt < half_units));
endmodule

// File: rtl/vclk_postdiv.sv
module vclk_postdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] post_div,
    output logic             pulse
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pulse;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clr || !run) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            if (st_q.cnt == post_div - DIV_W'(1)) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

    assert_post_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (st_q.cnt < post_div));
    assert_idle_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pulse);
    assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pulse);
    assert_no_adjacent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/vclk_gen.sv
module vclk_gen #(
    parameter int CFG_W   = vclk_pkg::CFG_W,
    parameter int NUM_SRC = vclk_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [NUM_SRC-1:0] src_half_tick,
    output logic               clk_en_o
);
    import vclk_pkg::*;

    localparam int MIN_DIV = 2;

    logic [CFG_W-1:0]  cfg_q;
    cfg_fields_t       fld;
    logic              run;
    logic              half_tick;
    logic              pre_tick;
    logic [HALF_W-1:0] half_units;

    vclk_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    assign fld        = unpack_cfg(cfg_q);
    assign half_units = {{(HALF_W-PRE_W){1'b0}}, fld.pre_code} + HALF_W'(3);
    assign run        = fld.en && (fld.pre_code != '0) && (fld.post_div >= DIV_W'(MIN_DIV));

    vclk_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
        .src_tick  (src_half_tick),
        .use_pll   (fld.use_pll),
        .pll_pick  (fld.pll_pick),
        .half_tick (half_tick)
    );

    vclk_prediv #(.HALF_W(HALF_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cfg_we),
        .run        (run),
        .half_tick  (half_tick),
        .half_units (half_units),
        .pre_tick   (pre_tick)
    );

    vclk_postdiv #(.DIV_W(DIV_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_we),
        .run      (run),
        .pre_tick (pre_tick),
        .post_div (fld.post_div),
        .pulse    (clk_en_o)
    );

    assign cfg_rdata = cfg_q;

    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[EN_BIT] && !cfg_we) |=> !clk_en_o);
    assert_code0_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rdata[PRE_LSB +: PRE_W] == '0) && !cfg_we) |=> !clk_en_o);
endmodule

// File: tb/vclk_gen_tb.sv
module vclk_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_OSC  = 4;
    localparam int P_PLL1 = 2;
    localparam int P_PLL2 = 1;
    localparam int WAIT_LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [2:0]  src_half_tick = '0;
    logic        clk_en_o;

    int n_checks = 0;
    int n_fail = 0;
    int tick_cnt [3] = '{0, 0, 0};
    int periods  [3] = '{P_OSC, P_PLL1, P_PLL2};

    vclk_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .src_half_tick (src_half_tick),
        .clk_en_o      (clk_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            for (int s = 0; s < 3; s++) begin
                tick_cnt[s] = (tick_cnt[s] >= periods[s] - 1) ? 0 : tick_cnt[s] + 1;
                src_half_tick[s] = (tick_cnt[s] == 0);
            end
        end
    end

    function automatic logic [15:0] mk(input bit en, input bit pick, input bit use_pll,
                                       input int code, input int dv);
        return {en, pick, use_pll, 4'b0000, 2'(code), 7'(dv)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic next_pulse(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            #1;
            cyc++;
        end while (!clk_en_o && cyc < WAIT_LIMIT);
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (clk_en_o) cnt++;
        end
    endtask

    // R5 / R4 / R3: measure spacing of three consecutive pulses
    task automatic t_period(input string req, input logic [15:0] v, input int exp_cyc);
        int c;
        write_cfg(v);
        next_pulse(c);
        for (int k = 0; k < 3; k++) begin
            next_pulse(c);
            check(c == exp_cyc, req, c, exp_cyc);
        end
    endtask

    task automatic t_reset;
        check(clk_en_o == 1'b0, "R1 clk_en_o", int'(clk_en_o), 0);
        check(cfg_rdata == 16'h0000, "R1 cfg_rdata", int'(cfg_rdata), 0);
    endtask

    task automatic t_readback;
        logic [15:0] v;
        v = 16'h5E5A;
        write_cfg(v);
        check(cfg_rdata == v, "R2 readback", int'(cfg_rdata), int'(v));
        v = 16'hA1A5;
        write_cfg(v);
        check(cfg_rdata == v, "R2 readback2", int'(cfg_rdata), int'(v));
    endtask

    task automatic t_idle(input string req, input logic [15:0] v);
        int cnt;
        write_cfg(v);
        count_pulses(600, cnt);
        check(cnt == 0, req, cnt, 0);
    endtask

    task automatic t_restart;
        int c;
        int lo;
        int hi;
        write_cfg(mk(1, 0, 0, 3, 4));
        count_pulses(37, c);
        write_cfg(mk(1, 0, 0, 3, 4));
        check(clk_en_o == 1'b0, "R9 quiet after write", int'(clk_en_o), 0);
        // first pulse: 24 osc strobes after the write edge
        lo = 23 * P_OSC + 1;
        hi = 24 * P_OSC;
        c = 1;
        while (!clk_en_o && c < WAIT_LIMIT) begin
            @(posedge clk);
            #1;
            c++;
        end
        check(c >= lo && c <= hi, "R9 first pulse", c, hi);
    endtask

    task automatic t_fastest;
        int c;
        int adj;
        write_cfg(mk(1, 1, 1, 1, 2));
        adj = 0;
        next_pulse(c);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1;
            if (clk_en_o) adj++;
            next_pulse(c);
            c++;
            check(c >= 8, "R10 min spacing", c, 8);
        end
        check(adj == 0, "R10 no adjacent", adj, 0);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                rst_n = 1'b1;
                t_reset();
                t_readback();
                t_period("R4 R5 ratio2 div3 osc", mk(1, 0, 0, 1, 3), 4*3*P_OSC);
                t_period("R4 R5 ratio2.5 div2 pll1", mk(1, 0, 1, 2, 2), 5*2*P_PLL1);
                t_period("R4 R5 ratio2.5 div7 pll2", mk(1, 1, 1, 2, 7), 5*7*P_PLL2);
                t_period("R4 R5 ratio3 div127 pll2", mk(1, 1, 1, 3, 127), 6*127*P_PLL2);
                t_period("R6 div2 min legal", mk(1, 1, 1, 1, 2), 8*P_PLL2);
                t_period("R3 pick ignored osc", mk(1, 1, 0, 1, 2), 8*P_OSC);
                t_period("R3 pll1 select", mk(1, 0, 1, 3, 5), 30*P_PLL1);
                t_idle("R6 div1 idle", mk(1, 1, 1, 1, 1));
                t_idle("R6 div0 idle", mk(1, 1, 1, 2, 0));
                t_idle("R7 code0 idle", mk(1, 1, 1, 0, 9));
                t_idle("R8 disabled idle", mk(0, 1, 1, 2, 3));
                t_restart();
                t_fastest();
            end
            begin
                while (wd < 150000) begin
                    @(posedge clk);
                    wd++;
                end
                check(1'b0, "watchdog", wd, 0);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule